// File: doc/BRIEF.md
# Indexed Real-Time Clock Register File

This block holds the register set of a PC-style battery-backed clock behind a two-address access scheme: software first writes an index, then reads or writes the selected register through a data address. Fourteen registers are reachable. Ten are plain bytes holding the time of day, the calendar date and three alarm bytes. The other four are status registers A to D. Time does not advance inside the block. The time bytes are loaded from a parallel preset input while reset is held, and after that software may overwrite them.

Register A holds a fixed time-base and rate code, and its update-in-progress bit flips on every read. This lets polling software see the bit change. Register B carries the periodic-interrupt enable. While that bit is set, a generator emits a one-cycle pulse every `tick_interval` clock cycles. Any write that the block cannot honour is dropped and raises a one-cycle error pulse. This covers an index above 0x0D, a value that is not supported in register A or B, and any write to register C or D.

Accesses arrive on a valid/ready request channel. Read data leaves on a valid/ready response channel. A new request is accepted only while the response register is empty or is being drained in the same cycle. Holding `rsp_ready` low therefore stalls the request side.

Top module: `rtc_indexed_regs`

## Requirements
- R1: A write to the index address (`req_sel`=0) with a value of 0x00 to 0x0D selects that register. A larger value is rejected: the error pulse fires and the index keeps its old value. The index resets to 0x00.
- R2: Indices 0x00 to 0x09 are byte registers that read back exactly the last value written to them. A write to one of them leaves the others unchanged. The layout is: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 weekday (starting at 1), 7 day of month, 8 month (starting at 1), 9 years since 1900. All values are binary.
- R3: While reset is held, the seven time bytes load from `preset_time`, packed from the low byte upward as seconds, minutes, hours, weekday, day of month, month, year. The three alarm bytes reset to 0x00.
- R4: Register A (index 0x0A) resets to 0x26. Each read first inverts bit 7 and then returns the new value, so the reads after reset return 0xA6, 0x26, 0xA6 and so on.
- R5: Register A accepts a write only of 0x26, which stores 0x26. Any other value is rejected with the error pulse and leaves the register unchanged.
- R6: Register B (index 0x0B) resets to 0x46: bit 6 is the periodic enable, bit 2 is binary mode and bit 1 is 24-hour mode. A write is accepted only if the value ANDed with 0xB7 equals 0x06. Only bit 6 and bit 3 (square-wave enable) may change. Any other value is rejected with the error pulse and leaves the register unchanged.
- R7: Registers C and D (0x0C, 0x0D) always read 0x00. Every write to them is rejected with the error pulse.
- R8: While the register B bit 6 is set, `periodic_irq` pulses for one cycle every `tick_interval` cycles. The first pulse comes `tick_interval` cycles after the write that sets the bit, or after reset is released. A `tick_interval` of 0 gives no pulses.
- R9: After a write that clears register B bit 6, no pulse appears later than the cycle that write takes effect. Setting the bit again restarts the interval count from zero.
- R10: `req_ready` is high exactly when `rsp_valid` is low or `rsp_ready` is high. Read data appears on `rsp_rdata` with `rsp_valid` one cycle after the read is accepted. Both stay unchanged while `rsp_ready` is low.
- R11: `wr_error` is high for one cycle in the cycle after a rejected write is accepted. It never fires for a read or for an accepted write.
- R12: A read of the index address returns the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the time preset loads while it is low |
| preset_time | input | 56 | Reset values for the seven time bytes, seconds in bits 7:0 up to year in bits 55:48 |
| tick_interval | input | TICK_W (16) | Periodic interrupt interval in clock cycles |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = index address, 1 = data address |
| req_wdata | input | 8 | Write value |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_rdata | output | 8 | Read data |
| periodic_irq | output | 1 | One-cycle periodic interrupt pulse |
| wr_error | output | 1 | One-cycle pulse for a rejected write |

## Verification
Each access goes through one register stage. Read data and `rsp_valid` appear just after the edge that accepts the read. `wr_error` appears after that same edge, and a changed index or register first shows on the next access. The directed tasks drive stimulus at the falling edge and sample 1 ns after the accepting rising edge. They count periodic pulses edge by edge from the write that changes the enable, so the first pulse is expected exactly `tick_interval` edges later and the next one a further `tick_interval` edges on. Back-pressure is checked by holding `rsp_ready` low across several edges and confirming that the response and the register state are frozen.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W   = 8;
  localparam int IDX_W    = 4;
  localparam int NUM_DATA = 10;
  localparam int LAST_IDX = 13;
  localparam int TIME_W   = 7 * BYTE_W;

  localparam logic [IDX_W-1:0] IDX_STAT_A = 4'hA;
  localparam logic [IDX_W-1:0] IDX_STAT_B = 4'hB;

  localparam logic [BYTE_W-1:0] STAT_A_INIT = 8'h26;
  localparam logic [BYTE_W-1:0] STAT_B_INIT = 8'h46;
  localparam logic [BYTE_W-1:0] STAT_B_FREE = 8'h48;
  localparam logic [BYTE_W-1:0] STAT_B_KEEP = 8'h06;
  localparam logic [BYTE_W-1:0] UIP_MASK    = 8'h80;
  localparam int PIE_BIT = 6;

  typedef struct packed {
    logic [BYTE_W-1:0] year;
    logic [BYTE_W-1:0] month;
    logic [BYTE_W-1:0] mday;
    logic [BYTE_W-1:0] wday;
    logic [BYTE_W-1:0] hour;
    logic [BYTE_W-1:0] minute;
    logic [BYTE_W-1:0] second;
  } rtc_time_t;

  function automatic logic [BYTE_W-1:0] preset_byte(input int slot, input rtc_time_t t);
    case (slot)
      0:       return t.second;
      2:       return t.minute;
      4:       return t.hour;
      6:       return t.wday;
      7:       return t.mday;
      8:       return t.month;
      9:       return t.year;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/rtc_access_port.sv
module rtc_access_port
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_sel,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_rdata,
  input  logic [BYTE_W-1:0] idx_value,
  input  logic [BYTE_W-1:0] data_value,
  output logic              idx_wr,
  output logic              data_wr,
  output logic              data_rd,
  output logic [BYTE_W-1:0] wdata
);
  logic accept;
  logic rd_accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rd_accept = accept && !req_write;
  assign idx_wr    = accept && req_write && !req_sel;
  assign data_wr   = accept && req_write && req_sel;
  assign data_rd   = rd_accept && req_sel;
  assign wdata     = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_sel ? data_value : idx_value;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] preset_time,
  input  logic              idx_wr,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] idx_value,
  output logic [BYTE_W-1:0] data_value,
  output logic              pie,
  output logic              wr_error
);
  rtc_time_t         preset;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] bytes_q [NUM_DATA];
  logic [BYTE_W-1:0] stat_a_q;
  logic [BYTE_W-1:0] stat_b_q;
  logic              is_byte;
  logic              bad_idx;
  logic              bad_data;

  assign preset  = rtc_time_t'(preset_time);
  assign is_byte = (idx_q < IDX_W'(NUM_DATA));

  always_comb begin
    bad_data = 1'b0;
    if (!is_byte) begin
      if (idx_q == IDX_STAT_A)      bad_data = (wdata != STAT_A_INIT);
      else if (idx_q == IDX_STAT_B) bad_data = ((wdata & ~STAT_B_FREE) != STAT_B_KEEP);
      else                          bad_data = 1'b1;
    end
  end

  assign bad_idx = (wdata > BYTE_W'(LAST_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      stat_a_q <= STAT_A_INIT;
      stat_b_q <= STAT_B_INIT;
      wr_error <= 1'b0;
      for (int i = 0; i < NUM_DATA; i++) bytes_q[i] <= preset_byte(i, preset);
    end else begin
      wr_error <= (idx_wr && bad_idx) || (data_wr && bad_data);
      if (idx_wr && !bad_idx) idx_q <= wdata[IDX_W-1:0];
      if (data_wr && !bad_data) begin
        if (is_byte) begin
          for (int i = 0; i < NUM_DATA; i++)
            if (idx_q == IDX_W'(i)) bytes_q[i] <= wdata;
        end else if (idx_q == IDX_STAT_A) begin
          stat_a_q <= wdata;
        end else if (idx_q == IDX_STAT_B) begin
          stat_b_q <= wdata;
        end
      end else if (data_rd && idx_q == IDX_STAT_A) begin
        stat_a_q <= stat_a_q ^ UIP_MASK;
      end
    end
  end

  always_comb begin
    data_value = '0;
    if (is_byte)                  data_value = bytes_q[idx_q];
    else if (idx_q == IDX_STAT_A) data_value = stat_a_q ^ UIP_MASK;
    else if (idx_q == IDX_STAT_B) data_value = stat_b_q;
  end

  assign idx_value = BYTE_W'(idx_q);
  assign pie       = stat_b_q[PIE_BIT];
endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [TICK_W-1:0] interval,
  output logic              pulse
);
  logic [TICK_W-1:0] cnt_q;
  logic [TICK_W:0]   cnt_next;
  logic              reached;

  assign cnt_next = {1'b0, cnt_q} + 1'b1;
  assign reached  = (interval != '0) && (cnt_next >= {1'b0, interval});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (!enable) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (reached) begin
      cnt_q <= '0;
      pulse <= 1'b1;
    end else begin
      cnt_q <= (interval == '0) ? '0 : cnt_next[TICK_W-1:0];
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_indexed_regs.sv
module rtc_indexed_regs
  import rtc_pkg::*;
#(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] preset_time,
  input  logic [TICK_W-1:0] tick_interval,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_sel,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic              periodic_irq,
  output logic              wr_error
);
  logic              idx_wr;
  logic              data_wr;
  logic              data_rd;
  logic [BYTE_W-1:0] wdata;
  logic [BYTE_W-1:0] idx_value;
  logic [BYTE_W-1:0] data_value;
  logic              pie;

  rtc_access_port u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_sel    (req_sel),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .idx_value  (idx_value),
    .data_value (data_value),
    .idx_wr     (idx_wr),
    .data_wr    (data_wr),
    .data_rd    (data_rd),
    .wdata      (wdata)
  );

  rtc_regfile u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .preset_time (preset_time),
    .idx_wr      (idx_wr),
    .data_wr     (data_wr),
    .data_rd     (data_rd),
    .wdata       (wdata),
    .idx_value   (idx_value),
    .data_value  (data_value),
    .pie         (pie),
    .wr_error    (wr_error)
  );

  rtc_periodic_gen #(.TICK_W(TICK_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (pie),
    .interval (tick_interval),
    .pulse    (periodic_irq)
  );
endmodule

// File: rtl/rtc_indexed_regs_checker.sv
module rtc_indexed_regs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_rdata,
  input logic       periodic_irq,
  input logic       wr_error,
  input logic       pie
);
  a_r10_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (rsp_valid && !rsp_ready));

  a_r10_response_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r11_error_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_error |-> $past(req_valid && req_ready && req_write));

  a_r9_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !pie |=> !periodic_irq);

  a_r8_pulse_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_irq |-> $past(pie));
endmodule

bind rtc_indexed_regs rtc_indexed_regs_checker i_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_rdata    (rsp_rdata),
  .periodic_irq (periodic_irq),
  .wr_error     (wr_error),
  .pie          (pie)
);

// File: tb/test_rtc_indexed_regs.sv
`timescale 1ns/1ps
module test_rtc_indexed_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [55:0] preset_time;
  logic [15:0] tick_interval = 16'd5;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_sel = 1'b0;
  logic [7:0]  req_wdata = 8'h00;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_rdata;
  logic        periodic_irq;
  logic        wr_error;

  int n_checks = 0;
  int n_fail = 0;
  logic       last_err;
  logic [7:0] rd;

  localparam logic [7:0] SEC = 8'h2D, MIN = 8'h1E, HOUR = 8'h17, WDAY = 8'h03;
  localparam logic [7:0] MDAY = 8'h1F, MON = 8'h0C, YEAR = 8'h7C;

  assign preset_time = {YEAR, MON, MDAY, WDAY, HOUR, MIN, SEC};

  always #5 clk = ~clk;

  rtc_indexed_regs #(.TICK_W(16)) i_rtc_indexed_regs (
    .clk(clk), .rst_n(rst_n), .preset_time(preset_time), .tick_interval(tick_interval),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_sel(req_sel),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .periodic_irq(periodic_irq), .wr_error(wr_error)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic sel, input logic [7:0] val);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_sel = sel; req_wdata = val;
    @(posedge clk); #1;
    last_err = wr_error;
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic sel, output logic [7:0] val);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_sel = sel;
    @(posedge clk); #1;
    check("R10 response valid", int'(rsp_valid), 1);
    val = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic read_reg(input logic [7:0] idx, output logic [7:0] val);
    do_write(1'b0, idx);
    do_read(1'b1, val);
  endtask

  task automatic t_reset;
    logic [7:0] exp [10];
    exp = '{SEC, 8'h00, MIN, 8'h00, HOUR, 8'h00, WDAY, MDAY, MON, YEAR};
    do_read(1'b0, rd);
    check("R1 index reset", rd, 0);
    for (int i = 0; i < 10; i++) begin
      read_reg(8'(i), rd);
      check("R3 preset byte", rd, exp[i]);
    end
    read_reg(8'h0B, rd);
    check("R6 regB reset", rd, 8'h46);
  endtask

  task automatic t_index;
    do_write(1'b0, 8'h03);
    check("R11 no error on valid index", last_err, 0);
    do_write(1'b0, 8'h0E);
    check("R1 index 0x0E rejected", last_err, 1);
    @(posedge clk); #1;
    check("R11 error is one cycle", wr_error, 0);
    do_read(1'b0, rd);
    check("R12 index unchanged", rd, 8'h03);
    do_write(1'b0, 8'hFF);
    check("R1 index 0xFF rejected", last_err, 1);
    do_write(1'b0, 8'h0D);
    check("R1 index 0x0D accepted", last_err, 0);
    do_read(1'b0, rd);
    check("R12 index read", rd, 8'h0D);
  endtask

  task automatic t_bytes;
    do_write(1'b0, 8'h01);
    do_write(1'b1, 8'h5A);
    check("R2 byte write no error", last_err, 0);
    do_read(1'b1, rd);
    check("R2 alarm byte readback", rd, 8'h5A);
    do_write(1'b0, 8'h09);
    do_write(1'b1, 8'h80);
    do_read(1'b1, rd);
    check("R2 year byte readback", rd, 8'h80);
    read_reg(8'h08, rd);
    check("R2 neighbour unchanged", rd, MON);
    read_reg(8'h00, rd);
    check("R2 seconds unchanged", rd, SEC);
  endtask

  task automatic t_reg_a;
    do_write(1'b0, 8'h0A);
    do_read(1'b1, rd); check("R4 first read", rd, 8'hA6);
    do_read(1'b1, rd); check("R4 second read", rd, 8'h26);
    do_read(1'b1, rd); check("R4 third read", rd, 8'hA6);
    do_write(1'b1, 8'h26); check("R5 write 0x26 accepted", last_err, 0);
    do_read(1'b1, rd); check("R5 read after write", rd, 8'hA6);
    do_write(1'b1, 8'h27); check("R5 write 0x27 rejected", last_err, 1);
    do_read(1'b1, rd); check("R5 unchanged after reject", rd, 8'h26);
  endtask

  task automatic t_reg_b;
    do_write(1'b0, 8'h0B);
    do_write(1'b1, 8'h4E); check("R6 write 0x4E accepted", last_err, 0);
    do_read(1'b1, rd); check("R6 readback 0x4E", rd, 8'h4E);
    do_write(1'b1, 8'h42); check("R6 binary clear rejected", last_err, 1);
    do_read(1'b1, rd); check("R6 unchanged after reject", rd, 8'h4E);
    do_write(1'b1, 8'hC6); check("R6 bit7 rejected", last_err, 1);
    do_write(1'b1, 8'h46); check("R6 write 0x46 accepted", last_err, 0);
    do_read(1'b1, rd); check("R6 readback 0x46", rd, 8'h46);
  endtask

  task automatic t_reg_cd;
    for (int r = 12; r < 14; r++) begin
      do_write(1'b0, 8'(r));
      do_read(1'b1, rd); check("R7 reads zero", rd, 0);
      do_write(1'b1, 8'h12); check("R7 write rejected", last_err, 1);
      do_read(1'b1, rd); check("R7 still zero", rd, 0);
    end
  endtask

  task automatic t_periodic;
    int pulses;
    int first;
    int second;
    do_write(1'b0, 8'h0B);
    do_write(1'b1, 8'h06);
    @(posedge clk);
    pulses = 0;
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); #1;
      if (periodic_irq) pulses++;
    end
    check("R9 no pulses when disabled", pulses, 0);
    do_write(1'b1, 8'h46);
    first = 0; second = 0;
    for (int k = 1; k <= 12; k++) begin
      @(posedge clk); #1;
      if (periodic_irq && first == 0) first = k;
      else if (periodic_irq && second == 0) second = k;
    end
    check("R8 first pulse after enable", first, 5);
    check("R8 second pulse", second, 10);
    @(negedge clk);
    tick_interval = 16'd0;
    pulses = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      if (periodic_irq) pulses++;
    end
    check("R8 zero interval gives no pulses", pulses, 0);
    @(negedge clk);
    tick_interval = 16'd3;
    pulses = 0;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #1;
      if (periodic_irq) pulses++;
    end
    check("R8 interval 3 pulse count", pulses, 4);
  endtask

  task automatic t_backpressure;
    do_write(1'b0, 8'h00);
    @(negedge clk);
    rsp_ready = 1'b0;
    do_read(1'b1, rd);
    check("R10 data", rd, SEC);
    check("R10 ready low while held", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_sel = 1'b0; req_wdata = 8'h05;
    repeat (3) @(posedge clk);
    #1;
    check("R10 response still valid", rsp_valid, 1);
    check("R10 response data held", rsp_rdata, SEC);
    @(negedge clk);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    check("R10 response drained", rsp_valid, 0);
    do_read(1'b0, rd);
    check("R10 stalled write not taken", rd, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index();
    t_bytes();
    t_reg_a();
    t_reg_b();
    t_reg_cd();
    t_periodic();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule